// File: doc/BRIEF.md
# Byte Lane Steering for a Narrow Peripheral Port

This block sits between a 32-bit processor bus and a peripheral that has only one byte of data path. It watches the processor's active-low byte enables when a bus cycle starts. From them it chooses which single upper byte lane, if any, must be routed onto the narrow data path. It also produces the two low address bits the peripheral needs to find that byte. External transceivers use the lane enables to connect the chosen byte of the wide bus to the 8-bit path.

The choice is made at the start of the cycle and held for the rest of it. On every clock edge where the active-low address strobe is low, the block registers a new selection. On all other edges the previous selection stays unchanged.

The rule is lowest-byte-first. Among the asserted byte enables, the lowest one decides the lane. When the lowest is byte 0, no upper lane is enabled, because byte 0 already lies on the narrow path. There are two cases where no upper lane is selected and the address is 00:
- the cycle is not marked as going to an 8-bit device;
- the byte-enable pattern can never occur, that is, it is empty or has gaps.

No byte-high-enable output exists. The interface is plain control signalling: it has no data stream and no back-pressure, and the strobe alone qualifies the inputs.

Top module: `lane_steer_top`

## Requirements
- R1: Lane enable bit 0 (second byte) goes low, and the address becomes 01, after a strobe edge in 8-bit mode where BE0 is deasserted, BE1 is asserted and the enables are contiguous.
- R2: Lane enable bit 1 (third byte) goes low, and the address becomes 10, after a strobe edge in 8-bit mode where BE0 and BE1 are deasserted, BE2 is asserted and the enables are contiguous.
- R3: Lane enable bit 2 (fourth byte) goes low, and the address becomes 11, after a strobe edge in 8-bit mode where only BE3 is asserted.
- R4: A contiguous pattern in 8-bit mode that includes BE0 (all four asserted among them) leaves every lane enable high and sets the address to 00.
- R5: On every clock edge where the address strobe is high, the lane enables and the address keep their previous values.
- R6: A strobe edge with the bus-size input high (not 8-bit) captures all lane enables high and the address 00.
- R7: A strobe edge in 8-bit mode with no byte enable asserted, or with non-contiguous enables, captures all lane enables high and the address 00.
- R8: A synchronous active-high reset drives all lane enables high and the address to 00 on the next edge, and reset takes priority over the strobe.
- R9: At most one lane enable is low at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ads_n | input | 1 | Address strobe, active low, marks the start of a cycle |
| bs8_n | input | 1 | Active low: the cycle targets an 8-bit device |
| be_n | input | 4 | Processor byte enables, active low, bit k for byte k |
| lane_en_n | output | 3 | Active-low lane enables, bit k-1 routes byte k to the narrow path |
| lane_addr | output | 2 | Low address bits for the peripheral (index of the chosen byte) |

## Verification
The bench covers gapped patterns such as bytes 1 and 3 asserted. A design that decodes only the lowest bit, as a plain priority encoder does, would wrongly enable the second lane for these. Fully asserted enables must leave every lane off. A design that picks the highest enable would steer the fourth byte instead.

Long runs with the strobe held high check that the selection is kept. A design that reloads every clock would follow the changing enables. The bench also drives reset together with an active strobe and switches the bus-size input between 8-bit and wider. These expose a design that gives the strobe priority over reset, or one that steers lanes for wide cycles.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;
  localparam int unsigned BUS_BYTES = 4;
  localparam int unsigned IDX_W     = $clog2(BUS_BYTES);
  localparam int unsigned UPPER     = BUS_BYTES - 1;

  typedef struct packed {
    logic [UPPER-1:0] lanes_n;
    logic [IDX_W-1:0] addr;
  } steer_sel_t;
endpackage

// File: rtl/lane_steer_decode.sv
module lane_steer_decode
  import lane_steer_pkg::*;
(
  input  logic [BUS_BYTES-1:0] be_n,
  input  logic                 bs8_n,
  output steer_sel_t           sel
);
  logic [BUS_BYTES-1:0] be;
  logic [BUS_BYTES-1:0] shifted;
  logic [IDX_W-1:0]     low;
  logic                 found;
  logic                 contig;

  assign be = ~be_n;

  // lowest asserted byte
  always_comb begin
    low   = '0;
    found = 1'b0;
    for (int i = 0; i < BUS_BYTES; i++) begin
      if (be[i] && !found) begin
        low   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  // a run of ones starting at the lowest byte must have no gap above it
  always_comb begin
    shifted = be >> low;
    contig  = found && ((shifted & (shifted + 1'b1)) == '0);
  end

  always_comb begin
    sel.lanes_n = '1;
    sel.addr    = '0;
    if (!bs8_n && contig) begin
      sel.addr = low;
      if (low != '0) sel.lanes_n[int'(low) - 1] = 1'b0;
    end
  end
endmodule

// File: rtl/lane_steer_hold.sv
module lane_steer_hold
  import lane_steer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  steer_sel_t next_sel,
  output steer_sel_t cur_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_sel.lanes_n <= '1;
      cur_sel.addr    <= '0;
    end else if (load) begin
      cur_sel <= next_sel;
    end
  end
endmodule

// File: rtl/lane_steer_top.sv
module lane_steer_top
  import lane_steer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ads_n,
  input  logic                 bs8_n,
  input  logic [BUS_BYTES-1:0] be_n,
  output logic [UPPER-1:0]     lane_en_n,
  output logic [IDX_W-1:0]     lane_addr
);
  steer_sel_t decoded;
  steer_sel_t held;

  lane_steer_decode u_decode (
    .be_n  (be_n),
    .bs8_n (bs8_n),
    .sel   (decoded)
  );

  lane_steer_hold u_hold (
    .clk      (clk),
    .rst      (rst),
    .load     (!ads_n),
    .next_sel (decoded),
    .cur_sel  (held)
  );

  assign lane_en_n = held.lanes_n;
  assign lane_addr = held.addr;
endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk
  import lane_steer_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 ads_n,
  input logic                 bs8_n,
  input logic [BUS_BYTES-1:0] be_n,
  input logic [UPPER-1:0]     lane_en_n,
  input logic [IDX_W-1:0]     lane_addr
);
  AST_SECOND_LANE: assert property (@(posedge clk) disable iff (rst)
    (!ads_n && !bs8_n && be_n[1:0] == 2'b01 && (be_n[3] || !be_n[2]))
    |=> (lane_en_n == 3'b110 && lane_addr == 2'd1)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    ads_n |=> ($stable(lane_en_n) && $stable(lane_addr))); // R5

  AST_WIDE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (!ads_n && bs8_n) |=> (&lane_en_n && lane_addr == '0)); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (&lane_en_n && lane_addr == '0)); // R8

  AST_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~lane_en_n)); // R9
endmodule

bind lane_steer_top lane_steer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ads_n     (ads_n),
  .bs8_n     (bs8_n),
  .be_n      (be_n),
  .lane_en_n (lane_en_n),
  .lane_addr (lane_addr)
);

// File: tb/tb_lane_steer_top.sv
module tb_lane_steer_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ads_n = 1'b1;
  logic       bs8_n = 1'b1;
  logic [3:0] be_n = 4'hF;
  logic [2:0] lane_en_n;
  logic [1:0] lane_addr;

  int checks = 0;
  int failures = 0;
  logic [2:0] m_lanes = 3'b111;
  logic [1:0] m_addr  = 2'b00;

  always #4 clk = ~clk;

  lane_steer_top dut (
    .clk(clk), .rst(rst), .ads_n(ads_n), .bs8_n(bs8_n), .be_n(be_n),
    .lane_en_n(lane_en_n), .lane_addr(lane_addr)
  );

  function automatic logic [4:0] expect_sel(input logic [3:0] ben, input logic b8n);
    logic [3:0] a;
    a = ~ben;
    if (b8n) return 5'b111_00;
    case (a)
      4'b0010, 4'b0110, 4'b1110: return 5'b110_01;
      4'b0100, 4'b1100:          return 5'b101_10;
      4'b1000:                   return 5'b011_11;
      4'b0001, 4'b0011, 4'b0111, 4'b1111: return 5'b111_00;
      default:                   return 5'b111_00;
    endcase
  endfunction

  function automatic string req_of(input logic r, input logic ads, input logic b8n,
                                   input logic [3:0] ben);
    logic [3:0] a;
    a = ~ben;
    if (r)   return "R8";
    if (ads) return "R5";
    if (b8n) return "R6";
    case (a)
      4'b0010, 4'b0110, 4'b1110: return "R1";
      4'b0100, 4'b1100:          return "R2";
      4'b1000:                   return "R3";
      4'b0001, 4'b0011, 4'b0111, 4'b1111: return "R4";
      default:                   return "R7";
    endcase
  endfunction

  task automatic step(input logic r, input logic ads, input logic b8n, input logic [3:0] ben);
    logic [4:0] e;
    string tag;
    @(negedge clk);
    rst = r; ads_n = ads; bs8_n = b8n; be_n = ben;
    tag = req_of(r, ads, b8n, ben);
    if (r) begin
      m_lanes = 3'b111; m_addr = 2'b00;
    end else if (!ads) begin
      e = expect_sel(ben, b8n);
      m_lanes = e[4:2]; m_addr = e[1:0];
    end
    @(posedge clk);
    #2;
    checks++;
    if (lane_en_n !== m_lanes || lane_addr !== m_addr) begin
      failures++;
      $display("FAIL %s lanes=%b addr=%b expected lanes=%b addr=%b",
               tag, lane_en_n, lane_addr, m_lanes, m_addr);
    end
    checks++;
    if ($countones(~lane_en_n) > 1) begin
      failures++;
      $display("FAIL R9 lanes=%b expected at most one low", lane_en_n);
    end
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog lanes=%b addr=%b expected run to complete", lane_en_n, lane_addr);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    step(1, 1, 1, 4'hF);          // R8 reset state
    step(0, 0, 0, 4'b1101);       // R1 byte 1 alone
    step(0, 1, 0, 4'b0000);       // R5 hold while idle
    step(0, 1, 1, 4'b0111);       // R5 hold
    step(0, 0, 0, 4'b1001);       // R1 bytes 1-2
    step(0, 0, 0, 4'b1011);       // R2 byte 2
    step(0, 0, 0, 4'b0011);       // R2 bytes 2-3
    step(0, 0, 0, 4'b0111);       // R3 byte 3
    step(0, 0, 0, 4'b0000);       // R4 all asserted
    step(0, 0, 0, 4'b0111);       // R3
    step(0, 0, 0, 4'b0101);       // R7 gapped 1,3
    step(0, 0, 0, 4'b0111);       // R3
    step(0, 0, 0, 4'b1111);       // R7 none
    step(0, 0, 0, 4'b1011);       // R2
    step(0, 0, 1, 4'b1011);       // R6 wide cycle
    step(0, 0, 0, 4'b0111);       // R3
    step(1, 0, 0, 4'b1101);       // R8 reset beats strobe
    step(0, 0, 0, 4'b0110);       // R7 gapped 0,3
    for (int i = 0; i < 600; i++) begin
      logic r, a, b;
      logic [3:0] be;
      r  = ($urandom % 40) == 0;
      a  = ($urandom % 3) != 0;
      b  = ($urandom % 4) == 0;
      be = 4'($urandom);
      step(r, a, b, be);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule